// File: doc/BRIEF.md
# Subcode serial receiver

This block sits between an optical-disc signal-processor front end and the graphics decoder. It takes in three signals: a frame-sync level, a block-sync level and a serial data line. It drives a read clock back to the front end. When a sync edge arrives, the block starts a timer. When the timer expires it checks the sync levels. If the levels are valid, the block issues exactly six read-clock pulses. It samples one data bit on the leading edge of each pulse. It then presents the six subcode channel bits, R through W, as one byte with a one-cycle valid strobe.

Two select pins choose one of three front-end timing variants. The variants differ in which frame-sync edge starts the timer, in which levels are checked, and in the read-clock polarity. A mute input disables the block: no frame qualifies, any frame in progress is aborted, and block-sync has no effect. When block-sync is seen, the next emitted symbol carries a block-start flag. Inputs are assumed to be already synchronous to `clk`.

Top module: `subcode_rx`

## Requirements
- R1: The pair {var_sel_hi, var_sel_lo} selects the variant. 2'b00 selects A, 2'b10 selects B and 2'b11 selects C. The unused code 2'b01 behaves as A.
- R2: In variants A and C, a rising frm_sync edge starts the timer. The frame qualifies only if, QUAL_DLY cycles after the edge, frm_sync is high and blk_sync is low. Otherwise the frame is dropped and no read-clock pulse is issued.
- R3: In variant B, a falling frm_sync edge starts the timer. The frame qualifies only if frm_sync is still low QUAL_DLY cycles after the edge. The level of blk_sync plays no part.
- R4: A qualified frame produces exactly six read-clock pulses. Each pulse is active for RCLK_HALF cycles and is followed by RCLK_HALF idle cycles. The first leading edge appears one cycle after the check.
- R5: rd_clk idles low and pulses high in variants A and B. It idles high and pulses low in variant C.
- R6: sub_data is sampled on each leading read-clock edge. The first sample is channel R. sym_byte holds R..W in bits 7..2, and bits 1:0 are zero.
- R7: sym_valid is a one-cycle pulse. It rises QUAL_DLY+12*RCLK_HALF+1 cycles after the cycle in which the sync edge is sampled.
- R8: While mute is high, no frame qualifies and blk_sync is ignored. Mute raised during a frame returns rd_clk to idle on the next cycle and suppresses that frame's symbol.
- R9: blk_sync high on any unmuted cycle in variant A or C sets a pending flag. That flag is output as blk_start with the next symbol only. If blk_sync is high in the same cycle a symbol is emitted, the flag goes to the following symbol. In variant B, blk_start is never set.
- R10: Frame-sync edges that occur while a frame is being timed or clocked are ignored.
- R11: A synchronous active-high rst stops the read clock, clears sym_byte, sym_valid, blk_start and the pending flag, and returns the timer to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| var_sel_hi | input | 1 | Variant select, upper bit |
| var_sel_lo | input | 1 | Variant select, lower bit |
| frm_sync | input | 1 | Frame-sync level from the front end |
| blk_sync | input | 1 | Block-sync level from the front end |
| sub_data | input | 1 | Serial subcode data |
| mute | input | 1 | Disables reception while high |
| rd_clk | output | 1 | Read clock to the front end |
| sym_byte | output | 8 | Last packed symbol, R in bit 7 |
| sym_valid | output | 1 | One-cycle strobe for a new symbol |
| blk_start | output | 1 | Marks the first symbol after block-sync |

## Verification
Block-sync recognition and symbol emission can fall on the same clock edge. In that case the flag must attach to the following symbol: it must neither be lost nor be applied to the current one. The bench computes the emission cycle from QUAL_DLY and RCLK_HALF. It raises blk_sync for exactly that cycle in variant C. It then expects blk_start to be low on the current symbol and high on the next one. Separately, the bench sweeps all 64 symbol values in every variant. In each frame it measures pulse count, pulse width, first-edge latency and strobe timing against those same computed cycles.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

  localparam int SYM_BITS = 6;
  localparam int SYM_W    = 8;

  typedef enum logic [1:0] {
    VAR_A = 2'd0,
    VAR_B = 2'd1,
    VAR_C = 2'd2
  } fe_variant_e;

  // Select pins to variant; the unused code 01 falls back to variant A.
  function automatic fe_variant_e decode_variant(input logic hi, input logic lo);
    case ({hi, lo})
      2'b10:   return VAR_B;
      2'b11:   return VAR_C;
      default: return VAR_A;
    endcase
  endfunction

  // Variant B starts timing on the falling sync edge, the others on the rising one.
  function automatic logic starts_on_rise(input fe_variant_e v);
    return v != VAR_B;
  endfunction

  // Level check made once the qualification delay has elapsed.
  function automatic logic qual_pass(input fe_variant_e v, input logic fs, input logic bs);
    if (v == VAR_B) return !fs;
    return fs && !bs;
  endfunction

  // Idle level of the read clock.
  function automatic logic rclk_idle(input fe_variant_e v);
    return v == VAR_C;
  endfunction

  // Block-sync is meaningful only in variants A and C and only when not muted.
  function automatic logic block_seen(input fe_variant_e v, input logic bs, input logic mu);
    return bs && !mu && (v != VAR_B);
  endfunction

  // First received bit (R) lands in the MSB; two zero pad bits at the bottom.
  function automatic logic [SYM_W-1:0] pack_symbol(input logic [SYM_BITS-1:0] bits);
    return {bits, {(SYM_W-SYM_BITS){1'b0}}};
  endfunction

endpackage

// File: rtl/sbc_sync_qual.sv
module sbc_sync_qual
  import sbc_pkg::*;
#(
  parameter int QUAL_DLY = 31
) (
  input  logic        clk,
  input  logic        rst,
  input  fe_variant_e variant,
  input  logic        fsync_i,
  input  logic        bsync_i,
  input  logic        mute_i,
  input  logic        busy_i,
  output logic        qual_ok_o,
  output logic        qual_fail_o,
  output logic        waiting_o
);

  localparam int QW = (QUAL_DLY > 1) ? $clog2(QUAL_DLY) : 1;
  localparam logic [QW-1:0] LAST = QW'(QUAL_DLY - 1);

  logic          fs_q;
  logic          wait_q;
  logic [QW-1:0] cnt_q;

  logic sync_edge;
  logic check_now;
  logic lvl_ok;

  assign sync_edge   = starts_on_rise(variant) ? (fsync_i & ~fs_q) : (~fsync_i & fs_q);
  assign check_now   = wait_q && (cnt_q == LAST);
  assign lvl_ok      = qual_pass(variant, fsync_i, bsync_i);
  assign qual_ok_o   = check_now && !mute_i && lvl_ok;
  assign qual_fail_o = wait_q && (mute_i || (check_now && !lvl_ok));
  assign waiting_o   = wait_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fs_q   <= 1'b0;
      wait_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      fs_q <= fsync_i;
      if (wait_q) begin
        if (mute_i || check_now) begin
          wait_q <= 1'b0;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (sync_edge && !busy_i && !mute_i) begin
        wait_q <= 1'b1;
        cnt_q  <= '0;
      end
    end
  end

  // R10: the timer is never armed while the read-clock sequencer runs
  p_idle_when_busy_r10: assert property (@(posedge clk) disable iff (rst)
    busy_i |-> !waiting_o);

  // R2: one check per edge; the timer is idle after a pass or a failure
  p_single_check_r2: assert property (@(posedge clk) disable iff (rst)
    (qual_ok_o || qual_fail_o) |=> !waiting_o);

endmodule

// File: rtl/sbc_rdclk_gen.sv
module sbc_rdclk_gen
  import sbc_pkg::*;
#(
  parameter int RCLK_HALF = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic abort_i,
  output logic ph_o,
  output logic sample_o,
  output logic done_o,
  output logic busy_o
);

  localparam int PER = 2 * RCLK_HALF;
  localparam int CW  = (PER > 1) ? $clog2(PER) : 1;
  localparam int BW  = $clog2(SYM_BITS);
  localparam logic [CW-1:0] C_HALF = CW'(RCLK_HALF);
  localparam logic [CW-1:0] C_LAST = CW'(PER - 1);
  localparam logic [BW-1:0] B_LAST = BW'(SYM_BITS - 1);

  logic          run_q;
  logic          ph_q;
  logic [CW-1:0] cnt_q;
  logic [BW-1:0] bit_q;

  assign sample_o = run_q && !abort_i && (cnt_q == '0);
  assign done_o   = run_q && !abort_i && (cnt_q == C_LAST) && (bit_q == B_LAST);
  assign ph_o     = ph_q;
  assign busy_o   = run_q;

  always_ff @(posedge clk) begin
    if (rst || abort_i) begin
      run_q <= 1'b0;
      ph_q  <= 1'b0;
      cnt_q <= '0;
      bit_q <= '0;
    end else if (!run_q) begin
      if (start_i) begin
        run_q <= 1'b1;
        cnt_q <= '0;
        bit_q <= '0;
      end
    end else begin
      if (cnt_q == '0)         ph_q <= 1'b1;
      else if (cnt_q == C_HALF) ph_q <= 1'b0;
      if (cnt_q == C_LAST) begin
        cnt_q <= '0;
        if (bit_q == B_LAST) run_q <= 1'b0;
        else                 bit_q <= bit_q + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // Checker state: samples taken since start and length of the current active phase.
  logic [BW:0] ck_samples;
  logic [CW:0] ck_hi;

  always_ff @(posedge clk) begin
    if (rst || start_i) ck_samples <= '0;
    else if (sample_o)  ck_samples <= ck_samples + 1'b1;
    if (rst)       ck_hi <= '0;
    else if (ph_q) ck_hi <= ck_hi + 1'b1;
    else           ck_hi <= '0;
  end

  // R4: six leading edges precede the end of a frame
  p_six_pulses_r4: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ck_samples == (BW+1)'(SYM_BITS));

  // R4: an unaborted active phase lasts RCLK_HALF cycles
  p_pulse_width_r4: assert property (@(posedge clk) disable iff (rst)
    ($fell(ph_q) && !$past(abort_i) && !$past(rst)) |-> ck_hi == (CW+1)'(RCLK_HALF));

  // R8: an abort stops the clock on the next cycle
  p_abort_stops_r8: assert property (@(posedge clk) disable iff (rst)
    abort_i |=> (!ph_o && !busy_o));

endmodule

// File: rtl/sbc_sym_pack.sv
module sbc_sym_pack
  import sbc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  fe_variant_e      variant,
  input  logic             mute_i,
  input  logic             bsync_i,
  input  logic             sdata_i,
  input  logic             sample_i,
  input  logic             done_i,
  output logic [SYM_W-1:0] sym_o,
  output logic             valid_o,
  output logic             blk_o
);

  logic [SYM_BITS-1:0] sh_q;
  logic [SYM_W-1:0]    sym_q;
  logic                valid_q;
  logic                blk_q;
  logic                pend_q;
  logic                seen;

  assign seen = block_seen(variant, bsync_i, mute_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q    <= '0;
      sym_q   <= '0;
      valid_q <= 1'b0;
      blk_q   <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      if (sample_i) sh_q <= {sh_q[SYM_BITS-2:0], sdata_i};
      valid_q <= done_i;
      if (done_i) begin
        sym_q  <= pack_symbol(sh_q);
        blk_q  <= pend_q;
        pend_q <= seen;
      end else begin
        blk_q <= 1'b0;
        if (seen) pend_q <= 1'b1;
      end
    end
  end

  assign sym_o   = sym_q;
  assign valid_o = valid_q;
  assign blk_o   = blk_q;

  // R6: pad bits stay zero on every delivered symbol
  p_pad_zero_r6: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> sym_o[SYM_W-SYM_BITS-1:0] == '0);

  // R7: the strobe lasts a single cycle
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  // R9: the block flag only travels with a symbol
  p_blk_with_sym_r9: assert property (@(posedge clk) disable iff (rst)
    blk_o |-> valid_o);

endmodule

// File: rtl/subcode_rx.sv
module subcode_rx
  import sbc_pkg::*;
#(
  parameter int QUAL_DLY  = 31,
  parameter int RCLK_HALF = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       var_sel_hi,
  input  logic       var_sel_lo,
  input  logic       frm_sync,
  input  logic       blk_sync,
  input  logic       sub_data,
  input  logic       mute,
  output logic       rd_clk,
  output logic [7:0] sym_byte,
  output logic       sym_valid,
  output logic       blk_start
);

  fe_variant_e variant;
  logic qual_ok, qual_fail, waiting;
  logic ph, sample, done, busy;

  assign variant = decode_variant(var_sel_hi, var_sel_lo);

  sbc_sync_qual #(.QUAL_DLY(QUAL_DLY)) u_qual (
    .clk        (clk),
    .rst        (rst),
    .variant    (variant),
    .fsync_i    (frm_sync),
    .bsync_i    (blk_sync),
    .mute_i     (mute),
    .busy_i     (busy),
    .qual_ok_o  (qual_ok),
    .qual_fail_o(qual_fail),
    .waiting_o  (waiting)
  );

  sbc_rdclk_gen #(.RCLK_HALF(RCLK_HALF)) u_gen (
    .clk     (clk),
    .rst     (rst),
    .start_i (qual_ok),
    .abort_i (mute),
    .ph_o    (ph),
    .sample_o(sample),
    .done_o  (done),
    .busy_o  (busy)
  );

  sbc_sym_pack u_pack (
    .clk     (clk),
    .rst     (rst),
    .variant (variant),
    .mute_i  (mute),
    .bsync_i (blk_sync),
    .sdata_i (sub_data),
    .sample_i(sample),
    .done_i  (done),
    .sym_o   (sym_byte),
    .valid_o (sym_valid),
    .blk_o   (blk_start)
  );

  assign rd_clk = ph ^ rclk_idle(variant);

  // R8: muting leaves the read clock at its idle level one cycle later
  p_mute_idle_r8: assert property (@(posedge clk) disable iff (rst)
    mute |=> rd_clk == rclk_idle(variant));

  // R8: no symbol is delivered for a cycle in which mute was high
  p_mute_no_sym_r8: assert property (@(posedge clk) disable iff (rst)
    mute |=> !sym_valid);

  // R4: a passing check is followed by a running sequencer and never coincides with a failure
  p_start_after_qual_r4: assert property (@(posedge clk) disable iff (rst)
    qual_ok |=> (busy && !waiting));

  p_ok_fail_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(qual_ok && qual_fail));

endmodule

// File: tb/sim_subcode_rx.sv
module sim_subcode_rx;

  localparam int QD   = 7;
  localparam int H    = 3;
  localparam int LAST = QD + 12 * H + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic s_hi = 1'b0, s_lo = 1'b0;
  logic fs = 1'b0, bs = 1'b0, sd = 1'b0, mu = 1'b0;
  logic       rck;
  logic [7:0] sym;
  logic       vld, blk;

  int checks = 0;
  int errors = 0;
  bit exp_pend = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  subcode_rx #(.QUAL_DLY(QD), .RCLK_HALF(H)) u0 (
    .clk(clk), .rst(rst), .var_sel_hi(s_hi), .var_sel_lo(s_lo),
    .frm_sync(fs), .blk_sync(bs), .sub_data(sd), .mute(mu),
    .rd_clk(rck), .sym_byte(sym), .sym_valid(vld), .blk_start(blk)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One frame seen from the front end's side.
  task automatic run_frame(input logic hi, input logic lo, input logic [5:0] bits,
                           input bit bs_chk, input bit bs_emit, input int drop_at,
                           input int mute_at, input int rst_at, input bit reedge,
                           input bit exp_ok);
    bit is_b   = hi & !lo;
    bit idle   = hi & lo;
    bit act_lv = is_b ? 1'b0 : 1'b1;
    bit ac     = !is_b;
    bit exp_blk = exp_pend | (bs_chk & ac & (mute_at != 0));
    int pulses = 0, first_t = 0, cur_w = 0, badw = 0, idx = 0;
    int nvalid = 0, vt = 0, got = 0, gotblk = 0, stop_bad = 0;
    bit prev_act = 1'b0;
    @(negedge clk);
    s_hi = hi; s_lo = lo; fs = !act_lv;
    repeat (3) @(negedge clk);
    check(rck === idle, "R5 idle level", rck, idle);
    sd = bits[5]; fs = act_lv; bs = bs_chk; mu = (mute_at == 0);
    for (int t = 1; t <= LAST + 6; t++) begin
      bit act;
      @(negedge clk);
      act = (rck !== idle);
      if (act && !prev_act) begin
        pulses++;
        if (pulses == 1) first_t = t;
      end
      if (act) cur_w++;
      if (!act && prev_act) begin
        if (cur_w != H) badw++;
        cur_w = 0;
        idx++;
        if (idx < 6) sd = bits[5-idx];
      end
      if ((mute_at > 0 && t == mute_at + 1) || (rst_at > 0 && t == rst_at + 1))
        if (act) stop_bad++;
      if (vld) begin nvalid++; vt = t; got = sym; gotblk = blk; end
      prev_act = act;
      if (t == drop_at) fs = !act_lv;
      if (bs_chk && t == QD + 1) bs = 1'b0;
      if (bs_emit && t == LAST - 1) bs = 1'b1;
      if (bs_emit && t == LAST) bs = 1'b0;
      if (t == mute_at) mu = 1'b1;
      if (t == rst_at) rst = 1'b1;
      if (rst_at > 0 && t == rst_at + 1) rst = 1'b0;
      if (reedge && t == QD + 10) fs = !act_lv;
      if (reedge && t == QD + 12) fs = act_lv;
    end
    if (mute_at > 0 || rst_at > 0) begin
      check(stop_bad == 0, mute_at > 0 ? "R8 clock stops on mute" : "R11 clock stops on reset", stop_bad, 0);
      check(nvalid == 0, mute_at > 0 ? "R8 no symbol after mute" : "R11 no symbol after reset", nvalid, 0);
    end else if (exp_ok) begin
      check(pulses == 6, "R4 pulse count", pulses, 6);
      check(first_t == QD + 2, "R4 first edge latency", first_t, QD + 2);
      check(badw == 0, "R4 pulse width", badw, 0);
      check(nvalid == 1, reedge ? "R10 single symbol" : "R7 one strobe", nvalid, 1);
      check(vt == LAST, "R7 strobe cycle", vt, LAST);
      check(got == {bits, 2'b00}, "R6 packed symbol", got, {bits, 2'b00});
      check(gotblk == exp_blk, "R9 block flag", gotblk, exp_blk);
    end else begin
      check(pulses == 0, mute_at == 0 ? "R8 muted frame clock" : (is_b ? "R3 dropped clock" : "R2 dropped clock"), pulses, 0);
      check(nvalid == 0, mute_at == 0 ? "R8 muted frame symbol" : (is_b ? "R3 dropped symbol" : "R2 dropped symbol"), nvalid, 0);
    end
    if (rst_at > 0)  exp_pend = 1'b0;
    else if (exp_ok && mute_at < 0) exp_pend = bs_emit & ac;
    else exp_pend = exp_blk;
    fs = !act_lv; mu = 1'b0; bs = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check(rck === 1'b0, "R11 reset rd_clk", rck, 0);
    check(vld === 1'b0, "R11 reset valid", vld, 0);
    check(blk === 1'b0, "R11 reset blk_start", blk, 0);
    check(sym === 8'h00, "R11 reset sym_byte", sym, 0);
    rst = 1'b0;
    // R1 R4 R5 R6 R7: every symbol value in each variant
    for (int v = 0; v < 3; v++)
      for (int s = 0; s < 64; s++)
        run_frame(v != 0, v == 2, 6'(s), 0, 0, -1, -1, -1, 0, 1);
    // R1: unused code behaves as variant A
    run_frame(1'b0, 1'b1, 6'b101101, 0, 0, -1, -1, -1, 0, 1);
    // R2: early frame-sync release and block-sync high at the check
    run_frame(1'b0, 1'b0, 6'h15, 0, 0, 3, -1, -1, 0, 0);
    run_frame(1'b0, 1'b0, 6'h2a, 1, 0, -1, -1, -1, 0, 0);
    // R9: the flag from the failed frame rides the next symbol only
    run_frame(1'b0, 1'b0, 6'h3c, 0, 0, -1, -1, -1, 0, 1);
    run_frame(1'b0, 1'b0, 6'h03, 0, 0, -1, -1, -1, 0, 1);
    // R3: variant B drop and block-sync disregarded
    run_frame(1'b1, 1'b0, 6'h21, 0, 0, 3, -1, -1, 0, 0);
    run_frame(1'b1, 1'b0, 6'h12, 1, 0, -1, -1, -1, 0, 1);
    // R9: block-sync on the emission edge goes to the following symbol
    run_frame(1'b1, 1'b1, 6'h0f, 0, 1, -1, -1, -1, 0, 1);
    run_frame(1'b1, 1'b1, 6'h30, 0, 0, -1, -1, -1, 0, 1);
    // R8: muted from the edge with block-sync high, then a clean frame
    run_frame(1'b0, 1'b0, 6'h11, 1, 0, -1, 0, -1, 0, 0);
    run_frame(1'b0, 1'b0, 6'h22, 0, 0, -1, -1, -1, 0, 1);
    // R8: mute in the middle of the pulses
    run_frame(1'b1, 1'b1, 6'h33, 0, 0, -1, QD + 5, -1, 0, 0);
    run_frame(1'b0, 1'b0, 6'h2d, 0, 0, -1, QD + 5, -1, 0, 0);
    // R10: a second edge during clocking is ignored
    run_frame(1'b0, 1'b0, 6'h19, 0, 0, -1, -1, -1, 1, 1);
    // R11: reset in the middle of a frame
    run_frame(1'b0, 1'b0, 6'h26, 0, 0, -1, -1, QD + 5, 0, 0);
    run_frame(1'b0, 1'b0, 6'h0a, 0, 0, -1, -1, -1, 0, 1);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule